// File: doc/BRIEF.md
# Quad Wiper Register Bank Controller

This block holds the register file and access logic behind a four-channel digital potentiometer. Every channel owns one live wiper register, which sets the wiper position (256 steps), plus four stored preset registers arranged as rows. A mode register decides whether a host access at a channel address reaches that channel's live wiper register or one of its presets. It also names which preset row is used.

The host drives a plain byte bus. A write strobe carries an address and a data byte. A read strobe carries an address, and the selected byte appears on the read port one cycle later. Writing the mode register with its enable bit set does two things at once: it switches later channel accesses to the preset row named in the same byte, and it loads that row into all four live wiper registers in a single step. The four wiper positions leave the block as one flat bus, taken straight from the live registers.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: After reset, every live wiper register, every preset register and the mode register hold 00h. `wipers_o` is all zero.
- R2: A write to address 07h stores bits 2..0 of the data in the mode register. Bits 7..3 always read back as 0. A read of 07h returns the mode register.
- R3: A mode write with data bit 0 = 1 copies preset row r = data[2:1], for every channel c, into that channel's live wiper register. The new values show on `wipers_o` after the clock edge that accepts the write.
- R4: When mode bit 0 = 0, a write to address c (0..3) loads channel c's live wiper register and leaves the other three unchanged. Channel c is output `wipers_o[8c+7:8c]`.
- R5: When mode bit 0 = 1, a write to address c (0..3) loads the preset of channel c in the row held in mode bits 2..1. No live wiper register changes.
- R6: A read strobe at address c (0..3) returns the preset of channel c in the current row when mode bit 0 = 1, and the live wiper register of channel c otherwise. `rd_data` shows the value in the cycle after the strobe and is 00h in any cycle that follows a cycle with no strobe.
- R7: Writes to any address other than 00h..03h and 07h change no register. Reads of those addresses return 00h.
- R8: A mode write with data bit 0 = 0 copies nothing, so the live wiper registers keep their values.
- R9: A read and a write in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| wipers_o | output | 32 | Four wiper positions, channel c at bits 8c+7..8c |

## Verification
On every cycle, the checker confirms the following:
- the reserved mode bits stay clear;
- each row copy lands in all four live registers on the next edge;
- a live register moves only on its own write or on a copy;
- no more than one register target fires per write;
- preset writes happen only in preset mode;
- unmapped writes disturb nothing;
- the read port idles at zero.

Only the bench's scenarios can show the following:
- that every preset of every row holds the value written to it;
- that reads follow the mode register across mode changes;
- that reserved bits are masked for real data patterns;
- that a read that collides with a write returns the old value.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int ROWS   = 4;
  localparam int ROW_W  = 2;
  localparam logic [7:0] MODE_ADDR = 8'h07;
  localparam logic [7:0] MODE_KEEP = 8'h07;

  function automatic logic [7:0] mode_clean(input logic [7:0] d);
    return d & MODE_KEEP;
  endfunction

  function automatic logic [ROW_W-1:0] mode_row(input logic [7:0] m);
    return m[2:1];
  endfunction

  function automatic logic mode_preset(input logic [7:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/wbc_mode_reg.sv
module wbc_mode_reg
  import wbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       wdata,
  output logic [7:0]       mode_q,
  output logic             copy_fire,
  output logic [ROW_W-1:0] copy_row
);
  assign copy_fire = we && mode_preset(wdata);
  assign copy_row  = mode_row(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 8'h00;
    else if (we) mode_q <= mode_clean(wdata);
  end
endmodule

// File: rtl/wbc_channel.sv
module wbc_channel
  import wbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wcr_we,
  input  logic                     dr_we,
  input  logic [ROW_W-1:0]         wr_row,
  input  logic [DW-1:0]            wdata,
  input  logic                     copy_en,
  input  logic [ROW_W-1:0]         copy_row,
  output logic [DW-1:0]            wcr_q,
  output logic [ROWS-1:0][DW-1:0]  dr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcr_q <= '0;
    end else if (copy_en) begin
      wcr_q <= dr_q[copy_row];
    end else if (wcr_we) begin
      wcr_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else if (dr_we) begin
      dr_q[wr_row] <= wdata;
    end
  end
endmodule

// File: rtl/wbc_read_mux.sv
module wbc_read_mux
  import wbc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int NCH = 4
) (
  input  logic [AW-1:0]                     addr,
  input  logic [7:0]                        mode_q,
  input  logic [NCH-1:0][DW-1:0]            wcr_all,
  input  logic [NCH-1:0][ROWS-1:0][DW-1:0]  dr_all,
  output logic [DW-1:0]                     value
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CW-1:0] chan;
  assign chan = addr[CW-1:0];

  always_comb begin
    value = '0;
    if (addr < AW'(NCH)) begin
      if (mode_preset(mode_q)) value = dr_all[chan][mode_row(mode_q)];
      else                     value = wcr_all[chan];
    end else if (addr == AW'(MODE_ADDR)) begin
      value = DW'(mode_q);
    end
  end
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wbc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NCH*DW-1:0] wipers_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [7:0]                        mode_q;
  logic                              status_wr;
  logic                              copy_fire;
  logic [ROW_W-1:0]                  copy_row;
  logic                              chan_hit;
  logic [CW-1:0]                     wr_chan;
  logic [NCH-1:0]                    wcr_wr;
  logic [NCH-1:0]                    dr_wr;
  logic [NCH-1:0][DW-1:0]            wcr_all;
  logic [NCH-1:0][ROWS-1:0][DW-1:0]  dr_all;
  logic [DW-1:0]                     rd_value;

  assign status_wr = wr_en && (wr_addr == AW'(MODE_ADDR));
  assign chan_hit  = wr_en && (wr_addr < AW'(NCH));
  assign wr_chan   = wr_addr[CW-1:0];

  wbc_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (status_wr),
    .wdata     (wr_data[7:0]),
    .mode_q    (mode_q),
    .copy_fire (copy_fire),
    .copy_row  (copy_row)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wcr_wr[c] = chan_hit && (wr_chan == CW'(c)) && !mode_preset(mode_q);
    assign dr_wr[c]  = chan_hit && (wr_chan == CW'(c)) &&  mode_preset(mode_q);

    wbc_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wcr_we   (wcr_wr[c]),
      .dr_we    (dr_wr[c]),
      .wr_row   (mode_row(mode_q)),
      .wdata    (wr_data),
      .copy_en  (copy_fire),
      .copy_row (copy_row),
      .wcr_q    (wcr_all[c]),
      .dr_q     (dr_all[c])
    );

    assign wipers_o[c*DW +: DW] = wcr_all[c];
  end

  wbc_read_mux #(.DW(DW), .AW(AW), .NCH(NCH)) u_rmux (
    .addr    (rd_addr),
    .mode_q  (mode_q),
    .wcr_all (wcr_all),
    .dr_all  (dr_all),
    .value   (rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_value;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker
  import wbc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int NCH = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [AW-1:0]                    wr_addr,
  input logic                             rd_en,
  input logic [DW-1:0]                    rd_data,
  input logic [7:0]                       mode_q,
  input logic                             copy_fire,
  input logic [ROW_W-1:0]                 copy_row,
  input logic [NCH-1:0]                   wcr_wr,
  input logic [NCH-1:0]                   dr_wr,
  input logic [NCH-1:0][DW-1:0]           wcr_all,
  input logic [NCH-1:0][ROWS-1:0][DW-1:0] dr_all
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7:3] == 5'd0);

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wcr_wr, dr_wr}));

  assert_preset_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dr_wr) |-> mode_q[0]);

  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(NCH) && wr_addr != AW'(MODE_ADDR))
      |=> ($stable(mode_q) && $stable(wcr_all) && $stable(dr_all)));

  assert_idle_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fire |=> wcr_all[c] == $past(dr_all[c][copy_row]));

    assert_wcr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wcr_wr[c] && !copy_fire) |=> $stable(wcr_all[c]));
  end
endmodule

bind wiper_bank_ctrl wbc_checker #(.DW(DW), .AW(AW), .NCH(NCH)) u_wbc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .mode_q    (mode_q),
  .copy_fire (copy_fire),
  .copy_row  (copy_row),
  .wcr_wr    (wcr_wr),
  .dr_wr     (dr_wr),
  .wcr_all   (wcr_all),
  .dr_all    (dr_all)
);

// File: tb/test_wiper_bank_ctrl.sv
module test_wiper_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [31:0] wipers_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_wcr [4];
  logic [7:0] m_dr  [4][4];
  logic [7:0] m_mode;

  always #2 clk = ~clk;

  wiper_bank_ctrl i_wiper_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wipers_o(wipers_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < 8'd4) return m_mode[0] ? m_dr[a[1:0]][m_mode[2:1]] : m_wcr[a[1:0]];
    if (a == 8'h07) return m_mode;
    return 8'h00;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h07) begin
      m_mode = {5'b0, d[2:0]};
      if (d[0]) for (int c = 0; c < 4; c++) m_wcr[c] = m_dr[c][d[2:1]];
    end else if (a < 8'd4) begin
      if (m_mode[0]) m_dr[a[1:0]][m_mode[2:1]] = d;
      else           m_wcr[a[1:0]] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic chk_wipers(input string tag);
    for (int c = 0; c < 4; c++) chk(wipers_o[c*8 +: 8], m_wcr[c], tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data, exp_rd(a), tag);
    @(negedge clk);
    chk(rd_data, 8'h00, "R6 idle read port");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_mode = 8'h00;
    for (int c = 0; c < 4; c++) begin
      m_wcr[c] = 8'h00;
      for (int r = 0; r < 4; r++) m_dr[c][r] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wipers_o[7:0], 8'h00, "R1 wiper0 reset");
    chk_wipers("R1 wipers reset");
    rd(8'h07, "R1 mode reset");
    for (int a = 0; a < 4; a++) rd(8'(a), "R1 live reset");

    // R4 live writes one channel at a time
    for (int c = 0; c < 4; c++) begin
      wr(8'(c), 8'(c * 37 + 5));
      chk_wipers("R4 single live write");
    end
    for (int a = 0; a < 4; a++) rd(8'(a), "R6 live read");

    // R5 preset writes, every row and channel
    for (int r = 0; r < 4; r++) begin
      wr(8'h07, 8'(r * 2));          // row select, bit0=0: no copy (R8)
      chk_wipers("R8 no copy on mode write");
      wr(8'h07, 8'(r * 2 + 1));      // preset mode on row r, copy fires (R3)
      chk_wipers("R3 copy on mode write");
      for (int c = 0; c < 4; c++) begin
        wr(8'(c), 8'((c * 64 + r * 16 + 9) ^ 8'hA5));
        chk_wipers("R5 preset write leaves wipers");
      end
      for (int c = 0; c < 4; c++) rd(8'(c), "R6 preset read");
      rd(8'h07, "R2 mode read");
    end

    // R3 copy each row into all wipers
    for (int r = 3; r >= 0; r--) begin
      wr(8'h07, 8'(r * 2 + 1));
      chk_wipers("R3 row copy to wipers");
    end

    // R2 reserved bits masked, data bits with high junk
    wr(8'h07, 8'hFC);
    rd(8'h07, "R2 reserved bits read 0");
    chk_wipers("R8 no copy with bit0 clear");
    wr(8'h07, 8'hAB);
    rd(8'h07, "R2 reserved bits read 0 copy");
    chk_wipers("R3 copy row 1 via masked byte");

    // back to live mode; check R8 and R6 follows mode
    wr(8'h07, 8'h00);
    for (int a = 0; a < 4; a++) rd(8'(a), "R6 read follows live mode");

    // R7 unmapped addresses
    for (int a = 4; a < 256; a++) begin
      if (a != 7) begin
        wr(8'(a), 8'hFF);
        rd(8'(a), "R7 unmapped read 00h");
      end
    end
    chk_wipers("R7 unmapped writes ignored");
    rd(8'h07, "R7 mode untouched");
    wr(8'h07, 8'h05);
    for (int a = 0; a < 4; a++) rd(8'(a), "R7 presets untouched");
    wr(8'h07, 8'h00);

    // R9 read and write same cycle
    begin
      logic [7:0] old_v;
      old_v = exp_rd(8'h02);
      wr_en = 1'b1; wr_addr = 8'h02; wr_data = 8'h3C;
      rd_en = 1'b1; rd_addr = 8'h02;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      model_wr(8'h02, 8'h3C);
      chk(rd_data, old_v, "R9 read returns pre-write value");
      chk_wipers("R9 write landed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule